// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block decides when a 16-bit processor takes an interrupt and then drives the stack traffic for entering and leaving the handler. It keeps an 18-bit interrupt state: a 16-bit handler address, a request bit that follows the external line one clock late, and an enable bit. The processor's stepper reports the start of each instruction on `step1_i`. A hardware interrupt is taken only at that moment. A software interrupt command starts the same entry at any idle cycle.

Entry takes two cycles. It saves the flags and then the program counter on a stack that grows downward. The last entry cycle loads the handler address into the program counter and disables interrupts. A return command restores state from the same stack in the opposite order: the program counter first, then the flags. The stack pointer is captured from `sp_i` when a sequence starts. The block returns its updated value on every stack cycle, and the register file stores that value. The stack memory sits outside the block. It returns read data in the same cycle as the address.

Top module: `irq_entry_ctrl`

## Requirements
- R1: `irq_i` is sampled into the request bit on every rising edge. A hardware entry starts only when the block is idle, `step1_i` is high, and both the request bit (the line level at the previous edge) and the enable bit are 1. A pulse on the line that has ended before the step-1 cycle causes no entry.
- R2: When the block is idle, `swi_i` starts an entry whatever the enable bit holds. If `swi_i` and `rti_i` arrive together, the entry wins and the return is dropped.
- R3: The first entry cycle writes the captured flags, zero-extended to 16 bits, at captured SP−1. The second entry cycle writes the captured PC at SP−2. On each write, `sp_we_o` is high and `sp_o` equals the write address. Write and read requests never occur together.
- R4: The second entry cycle also drives `pc_we_o` with `pc_o` equal to the handler address held at that cycle.
- R5: The enable bit reads 0 after the second entry cycle, even if `ien_set_i` is asserted in that same cycle.
- R6: Return lasts two cycles. The first cycle reads at captured SP and loads the returned word into the PC. The second cycle reads at SP+1 and loads bits [1:0] of the returned word into the flags. `sp_o` is the read address plus 1 on each read.
- R7: The handler address changes only on `set_vec_i`, and the new value takes effect from the next cycle.
- R8: After reset, the handler address and the enable bit are 0, the block is idle, and all request strobes are low. In idle, all data outputs are 0.
- R9: While a sequence is running, `swi_i`, `rti_i` and hardware requests are ignored. `set_vec_i`, `ien_set_i` and `ien_clr_i` still act.
- R10: `ien_set_i` sets the enable bit and `ien_clr_i` clears it. When both are asserted in the same cycle, clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | External interrupt line |
| step1_i | input | 1 | Stepper is at step 1 this cycle |
| swi_i | input | 1 | Software interrupt command |
| rti_i | input | 1 | Return-from-interrupt command |
| set_vec_i | input | 1 | Write the handler address |
| vec_i | input | 16 | New handler address |
| ien_set_i | input | 1 | Enable interrupts |
| ien_clr_i | input | 1 | Disable interrupts |
| pc_i | input | 16 | Current program counter |
| flags_i | input | 2 | Current flags (carry, zero) |
| sp_i | input | 16 | Current stack pointer |
| stk_rdata_i | input | 16 | Stack read data, same cycle as the address |
| stk_we_o | output | 1 | Stack write request |
| stk_re_o | output | 1 | Stack read request |
| stk_addr_o | output | 16 | Stack address |
| stk_wdata_o | output | 16 | Stack write data |
| sp_we_o | output | 1 | Stack pointer update strobe |
| sp_o | output | 16 | New stack pointer |
| pc_we_o | output | 1 | Program counter load strobe |
| pc_o | output | 16 | Program counter load value |
| flags_we_o | output | 1 | Flags restore strobe |
| flags_o | output | 2 | Flags restore value |
| busy_o | output | 1 | A sequence is running |
| ien_o | output | 1 | Interrupt enable bit |

## Verification
Several events can land in the same cycle, and each collision is forced on purpose. In one step-1 cycle, a held hardware request meets a software command; exactly one entry must follow. An `ien_set_i` is driven in the final entry cycle, so it coincides with the entry's own disable; the enable bit must read 0 afterwards. A `set_vec_i` is also placed on that final entry cycle, and the PC load must carry the old address. `swi_i` and `rti_i` are also raised together, and set and clear are raised together. Every outcome is judged against a behavioural model that is compared on every clock.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_PUSH_FL = 3'd1,
    SQ_PUSH_PC = 3'd2,
    SQ_POP_PC  = 3'd3,
    SQ_POP_FL  = 3'd4
  } sq_state_e;
endpackage

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         irq_i,
  input  logic         set_vec_i,
  input  logic [W-1:0] vec_i,
  input  logic         ien_set_i,
  input  logic         ien_clr_i,
  input  logic         entry_last_i,
  output logic [W-1:0] vec_o,
  output logic         req_o,
  output logic         ien_o
);
  localparam int StateW = W + 2;

  logic [StateW-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else begin
      if (set_vec_i) st_q[StateW-1:2] <= vec_i;
      st_q[1] <= irq_i;
      // entry disable outranks clear, which outranks set
      if (entry_last_i)   st_q[0] <= 1'b0;
      else if (ien_clr_i) st_q[0] <= 1'b0;
      else if (ien_set_i) st_q[0] <= 1'b1;
    end
  end

  assign vec_o = st_q[StateW-1:2];
  assign req_o = st_q[1];
  assign ien_o = st_q[0];
endmodule

// File: rtl/irq_stack_fsm.sv
module irq_stack_fsm
  import irq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      hw_take_i,
  input  logic      swi_i,
  input  logic      rti_i,
  output sq_state_e state_o,
  output logic      start_o,
  output logic      entry_last_o
);
  sq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (swi_i || hw_take_i) state_d = SQ_PUSH_FL;
        else if (rti_i)         state_d = SQ_POP_PC;
      end
      SQ_PUSH_FL: state_d = SQ_PUSH_PC;
      SQ_PUSH_PC: state_d = SQ_IDLE;
      SQ_POP_PC:  state_d = SQ_POP_FL;
      SQ_POP_FL:  state_d = SQ_IDLE;
      default:    state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SQ_IDLE;
    else         state_q <= state_d;
  end

  assign state_o      = state_q;
  assign start_o      = (state_q == SQ_IDLE) && (swi_i || hw_take_i || rti_i);
  assign entry_last_o = (state_q == SQ_PUSH_PC);
endmodule

// File: rtl/irq_stack_dp.sv
module irq_stack_dp
  import irq_pkg::*;
#(
  parameter int W  = 16,
  parameter int FW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  sq_state_e     state_i,
  input  logic          start_i,
  input  logic [W-1:0]  sp_i,
  input  logic [W-1:0]  pc_i,
  input  logic [FW-1:0] flags_i,
  input  logic [W-1:0]  vec_i,
  input  logic [W-1:0]  stk_rdata_i,
  output logic          stk_we_o,
  output logic          stk_re_o,
  output logic [W-1:0]  stk_addr_o,
  output logic [W-1:0]  stk_wdata_o,
  output logic          sp_we_o,
  output logic [W-1:0]  sp_o,
  output logic          pc_we_o,
  output logic [W-1:0]  pc_o,
  output logic          flags_we_o,
  output logic [FW-1:0] flags_o
);
  localparam logic [W-1:0] One = W'(1);

  logic [W-1:0]  sp_q, pc_q, sp_dn, sp_up;
  logic [FW-1:0] fl_q;

  assign sp_dn = sp_q - One;
  assign sp_up = sp_q + One;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
      pc_q <= '0;
      fl_q <= '0;
    end else if (start_i) begin
      sp_q <= sp_i;
      pc_q <= pc_i;
      fl_q <= flags_i;
    end else begin
      unique case (state_i)
        SQ_PUSH_FL, SQ_PUSH_PC: sp_q <= sp_dn;
        SQ_POP_PC, SQ_POP_FL:   sp_q <= sp_up;
        default:                sp_q <= sp_q;
      endcase
    end
  end

  always_comb begin
    stk_we_o    = 1'b0;
    stk_re_o    = 1'b0;
    stk_addr_o  = '0;
    stk_wdata_o = '0;
    sp_we_o     = 1'b0;
    sp_o        = '0;
    pc_we_o     = 1'b0;
    pc_o        = '0;
    flags_we_o  = 1'b0;
    flags_o     = '0;
    unique case (state_i)
      SQ_PUSH_FL: begin
        stk_we_o    = 1'b1;
        stk_addr_o  = sp_dn;
        stk_wdata_o = {{(W-FW){1'b0}}, fl_q};
        sp_we_o     = 1'b1;
        sp_o        = sp_dn;
      end
      SQ_PUSH_PC: begin
        stk_we_o    = 1'b1;
        stk_addr_o  = sp_dn;
        stk_wdata_o = pc_q;
        sp_we_o     = 1'b1;
        sp_o        = sp_dn;
        pc_we_o     = 1'b1;
        pc_o        = vec_i;
      end
      SQ_POP_PC: begin
        stk_re_o   = 1'b1;
        stk_addr_o = sp_q;
        sp_we_o    = 1'b1;
        sp_o       = sp_up;
        pc_we_o    = 1'b1;
        pc_o       = stk_rdata_i;
      end
      SQ_POP_FL: begin
        stk_re_o   = 1'b1;
        stk_addr_o = sp_q;
        sp_we_o    = 1'b1;
        sp_o       = sp_up;
        flags_we_o = 1'b1;
        flags_o    = stk_rdata_i[FW-1:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_pkg::*;
#(
  parameter int W  = 16,
  parameter int FW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          irq_i,
  input  logic          step1_i,
  input  logic          swi_i,
  input  logic          rti_i,
  input  logic          set_vec_i,
  input  logic [W-1:0]  vec_i,
  input  logic          ien_set_i,
  input  logic          ien_clr_i,
  input  logic [W-1:0]  pc_i,
  input  logic [FW-1:0] flags_i,
  input  logic [W-1:0]  sp_i,
  input  logic [W-1:0]  stk_rdata_i,
  output logic          stk_we_o,
  output logic          stk_re_o,
  output logic [W-1:0]  stk_addr_o,
  output logic [W-1:0]  stk_wdata_o,
  output logic          sp_we_o,
  output logic [W-1:0]  sp_o,
  output logic          pc_we_o,
  output logic [W-1:0]  pc_o,
  output logic          flags_we_o,
  output logic [FW-1:0] flags_o,
  output logic          busy_o,
  output logic          ien_o
);
  logic [W-1:0] vec_q;
  logic         req_q, ien_q, hw_take, start, entry_last;
  sq_state_e    state;

  irq_ctl_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni, .irq_i, .set_vec_i, .vec_i, .ien_set_i, .ien_clr_i,
    .entry_last_i(entry_last),
    .vec_o(vec_q), .req_o(req_q), .ien_o(ien_q)
  );

  assign hw_take = step1_i && req_q && ien_q;

  irq_stack_fsm u_fsm (
    .clk_i, .rst_ni, .hw_take_i(hw_take), .swi_i, .rti_i,
    .state_o(state), .start_o(start), .entry_last_o(entry_last)
  );

  irq_stack_dp #(.W(W), .FW(FW)) u_dp (
    .clk_i, .rst_ni, .state_i(state), .start_i(start),
    .sp_i, .pc_i, .flags_i, .vec_i(vec_q), .stk_rdata_i,
    .stk_we_o, .stk_re_o, .stk_addr_o, .stk_wdata_o,
    .sp_we_o, .sp_o, .pc_we_o, .pc_o, .flags_we_o, .flags_o
  );

  assign busy_o = (state != SQ_IDLE);
  assign ien_o  = ien_q;
endmodule

// File: rtl/irq_entry_ctrl_chk.sv
module irq_entry_ctrl_chk #(
  parameter int W  = 16,
  parameter int FW = 2
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         step1_i,
  input logic         swi_i,
  input logic         rti_i,
  input logic         set_vec_i,
  input logic         ien_set_i,
  input logic         ien_clr_i,
  input logic         req_q,
  input logic         ien_q,
  input logic [W-1:0] vec_q,
  input logic         stk_we_o,
  input logic         stk_re_o,
  input logic [W-1:0] stk_addr_o,
  input logic         sp_we_o,
  input logic [W-1:0] sp_o,
  input logic         pc_we_o,
  input logic [W-1:0] pc_o,
  input logic         flags_we_o,
  input logic         busy_o,
  input logic         ien_o
);
  AST_HW_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && step1_i && req_q && ien_q |=> stk_we_o && !pc_we_o); // R1
  AST_SW_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && swi_i |=> stk_we_o && !pc_we_o); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !swi_i && !rti_i && !(step1_i && req_q && ien_q) |=> !busy_o); // R9
  AST_PUSH_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_we_o && !pc_we_o |=> stk_we_o && pc_we_o &&
    stk_addr_o == $past(stk_addr_o) - W'(1)); // R3
  AST_SP_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_we_o |-> sp_we_o && sp_o == stk_addr_o); // R3
  AST_RW_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stk_we_o && stk_re_o)); // R3
  AST_VEC_TO_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_we_o && pc_we_o |-> pc_o == vec_q); // R4
  AST_DIS_AFTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_we_o && pc_we_o |=> !ien_o); // R5
  AST_POP_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_re_o && pc_we_o |=> stk_re_o && flags_we_o &&
    stk_addr_o == $past(stk_addr_o) + W'(1)); // R6
  AST_VEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_vec_i |=> $stable(vec_q)); // R7
  AST_IEN_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ien_set_i && ien_clr_i |=> !ien_o); // R10
endmodule

bind irq_entry_ctrl irq_entry_ctrl_chk #(.W(W), .FW(FW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .step1_i(step1_i), .swi_i(swi_i),
  .rti_i(rti_i), .set_vec_i(set_vec_i), .ien_set_i(ien_set_i),
  .ien_clr_i(ien_clr_i), .req_q(req_q), .ien_q(ien_q), .vec_q(vec_q),
  .stk_we_o(stk_we_o), .stk_re_o(stk_re_o), .stk_addr_o(stk_addr_o),
  .sp_we_o(sp_we_o), .sp_o(sp_o), .pc_we_o(pc_we_o), .pc_o(pc_o),
  .flags_we_o(flags_we_o), .busy_o(busy_o), .ien_o(ien_o)
);

// File: tb/irq_entry_ctrl_tb.sv
`timescale 1ns/1ps
module irq_entry_ctrl_tb;
  localparam int W = 16;
  localparam int FW = 2;
  localparam int BW = 73;

  logic clk = 1'b0, rst_n = 1'b0;
  logic irq = 0, step1 = 0, swi = 0, rti = 0, set_vec = 0, ien_set = 0, ien_clr = 0;
  logic [W-1:0] vec = '0, pc = '0, sp = '0;
  logic [FW-1:0] flags = '0;
  logic [W-1:0] rdata;
  logic stk_we, stk_re, sp_we, pc_we, flags_we, busy, ien;
  logic [W-1:0] stk_addr, stk_wdata, sp_o, pc_o;
  logic [FW-1:0] flags_o;

  logic [W-1:0] mem [256];
  assign rdata = mem[stk_addr[7:0]];

  always #5 clk = ~clk;

  irq_entry_ctrl #(.W(W), .FW(FW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .step1_i(step1), .swi_i(swi),
    .rti_i(rti), .set_vec_i(set_vec), .vec_i(vec), .ien_set_i(ien_set),
    .ien_clr_i(ien_clr), .pc_i(pc), .flags_i(flags), .sp_i(sp),
    .stk_rdata_i(rdata), .stk_we_o(stk_we), .stk_re_o(stk_re),
    .stk_addr_o(stk_addr), .stk_wdata_o(stk_wdata), .sp_we_o(sp_we),
    .sp_o(sp_o), .pc_we_o(pc_we), .pc_o(pc_o), .flags_we_o(flags_we),
    .flags_o(flags_o), .busy_o(busy), .ien_o(ien)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  int m_ph = 0;
  logic [W-1:0] m_sp = '0, m_pc = '0, m_vec = '0;
  logic [FW-1:0] m_fl = '0;
  logic m_req = 0, m_ien = 0;

  task automatic chk(input logic [BW-1:0] got, input logic [BW-1:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [BW-1:0] expected();
    logic [W-1:0] a, wd, spn, pcv;
    logic we, re, spw, pcw, flw;
    logic [FW-1:0] fl;
    {we, re, a, wd, spw, spn, pcw, pcv, flw, fl} = '0;
    case (m_ph)
      1: begin we = 1; a = m_sp - 1; wd = W'(m_fl); spw = 1; spn = m_sp - 1; end
      2: begin we = 1; a = m_sp - 1; wd = m_pc; spw = 1; spn = m_sp - 1; pcw = 1; pcv = m_vec; end
      3: begin re = 1; a = m_sp; spw = 1; spn = m_sp + 1; pcw = 1; pcv = mem[m_sp[7:0]]; end
      4: begin re = 1; a = m_sp; spw = 1; spn = m_sp + 1; flw = 1; fl = mem[m_sp[7:0]][FW-1:0]; end
      default: ;
    endcase
    return {we, re, a, wd, spw, spn, pcw, pcv, flw, fl, m_ph != 0, m_ien};
  endfunction

  function automatic logic [BW-1:0] observed();
    return {stk_we, stk_re, stk_addr, stk_wdata, sp_we, sp_o, pc_we, pc_o,
            flags_we, flags_o, busy, ien};
  endfunction

  function automatic string ph_tag();
    case (m_ph)
      0: return "R1 idle";
      1: return "R3 push flags";
      2: return "R4 push pc";
      default: return "R6 pop";
    endcase
  endfunction

  task automatic model_edge();
    int nph = m_ph;
    logic nien = m_ien;
    if (m_ph == 0) begin
      if (swi || (step1 && m_req && m_ien)) begin
        nph = 1; m_sp = sp; m_pc = pc; m_fl = flags;
      end else if (rti) begin
        nph = 3; m_sp = sp;
      end
    end else if (m_ph == 1) begin
      mem[8'(m_sp - 1)] = W'(m_fl); m_sp = m_sp - 1; nph = 2;
    end else if (m_ph == 2) begin
      mem[8'(m_sp - 1)] = m_pc; m_sp = m_sp - 1; nph = 0;
    end else begin
      m_sp = m_sp + 1; nph = (m_ph == 3) ? 4 : 0;
    end
    if (ien_set) nien = 1;
    if (ien_clr) nien = 0;
    if (m_ph == 2) nien = 0;
    if (set_vec) m_vec = vec;
    m_req = irq;
    m_ien = nien;
    m_ph = nph;
  endtask

  // compare, clock, then release single-cycle commands
  task automatic cyc();
    #1 chk(observed(), expected(), ph_tag());
    @(posedge clk);
    model_edge();
    @(negedge clk);
    {step1, swi, rti, set_vec, ien_set, ien_clr} = '0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = W'(i * 7);
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(observed(), '0, "R8 reset outputs");
    rst_n = 1'b1;
    run(2);

    // R2 + R8: software entry with enable 0, vector still 0
    sp = 16'h0080; pc = 16'h1234; flags = 2'b11; swi = 1;
    cyc();
    #1 chk({stk_we, stk_addr, stk_wdata}, {1'b1, 16'h007f, 16'h0003}, "R3 flags word");
    run(1);
    #1 chk({pc_we, pc_o, stk_addr, stk_wdata}, {1'b1, 16'h0000, 16'h007e, 16'h1234}, "R8 vector zero");
    run(2);
    chk(BW'(busy), BW'(0), "R2 entry done");

    // R7 + R10: set vector and enable
    vec = 16'h4000; set_vec = 1; ien_set = 1;
    cyc();
    chk(BW'(ien), BW'(1), "R10 enable set");

    // R1: line pulse that ends before step 1
    irq = 1; run(1); irq = 0; run(1);
    step1 = 1; run(1);
    chk(BW'(busy), BW'(0), "R1 dropped pulse ignored");
    run(2);

    // R1 + R2 + R4 + R5 + R7: held line, sw cmd same cycle, set_vec and ien_set on last entry cycle
    irq = 1; run(1);
    sp = 16'h007e; pc = 16'h2222; flags = 2'b10; step1 = 1; swi = 1;
    cyc();
    swi = 1; rti = 1; step1 = 1; run(1);     // R9 ignored while busy
    vec = 16'h5555; set_vec = 1; ien_set = 1;
    #1 chk({pc_we, pc_o}, {1'b1, 16'h4000}, "R7 old vector used");
    cyc();
    chk(BW'(ien), BW'(0), "R5 disable beats set");
    chk(BW'(busy), BW'(0), "R1 single entry");
    irq = 0;
    run(2);

    // R6: return from the frame at 0x7c
    sp = 16'h007c; rti = 1; cyc();
    #1 chk({pc_we, pc_o, sp_o}, {1'b1, 16'h2222, 16'h007d}, "R6 pc pop");
    run(1);
    #1 chk({flags_we, flags_o, sp_o}, {1'b1, 2'b10, 16'h007e}, "R6 flags pop");
    run(2);

    // R2: swi and rti together -> entry
    sp = 16'h0090; pc = 16'h0abc; flags = 2'b01; swi = 1; rti = 1;
    cyc();
    #1 chk({stk_we, stk_re}, {1'b1, 1'b0}, "R2 entry beats return");
    run(3);

    // R10: set and clear together
    ien_set = 1; cyc();
    ien_set = 1; ien_clr = 1; cyc();
    chk(BW'(ien), BW'(0), "R10 clear wins");
    // R1: held line with enable 0 is not taken
    irq = 1; run(1); step1 = 1; run(1);
    chk(BW'(busy), BW'(0), "R1 disabled not taken");
    // enabled, hardware only, vector 0x5555
    ien_set = 1; cyc();
    sp = 16'h00a0; pc = 16'h7777; flags = 2'b00; step1 = 1; cyc();
    irq = 0;
    run(1);
    #1 chk({pc_we, pc_o}, {1'b1, 16'h5555}, "R4 new vector");
    run(3);
    sp = 16'h009e; rti = 1; run(4);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule